// File: doc/BRIEF.md
# Infrared receive run-length sampler

This block watches a demodulated infrared receiver line and turns it into a stream of run-length bytes. The line is resynchronised to the local clock and can be inverted. It is then sampled once per time unit of 10 µs, a tick made by dividing the clock. Each run of equal level becomes one or more bytes. Bit 7 of a byte gives the level of the run: 0 means the emitter was on (pulse) and 1 means it was off (space). Bits 6:0 hold the length of the run in ticks. The bytes go into a small FIFO, and a host drains it through a plain read strobe.

Three things are visible to the host. A line status byte shows whether data is waiting and whether the FIFO has overflowed. An interrupt status byte and an interrupt line show the same two conditions, each gated by its own enable. A line-idle flag shows that a long space has closed the current message. Long runs are split into full 127-tick bytes. A change of level writes out the pending run at once. A disable input holds the sampler in its idle state.

Top module: `ir_rx_sampler`

## Requirements
- R1: After reset, lineStatus and irqStatus read 0x00, irq is low, lineIdle is high and rxByte reads 0x00.
- R2: Every stored byte carries the run level in bit 7 (0 = pulse, 1 = space) and the run length in bits 6:0, counted in ticks of TICK_CYCLES clocks (10 µs each).
- R3: When the sampled level differs from the current run at a tick, the pending run is written as one byte in that tick, whatever its length, and the new run starts with a length of 1.
- R4: A run of 127 ticks or more is written as full bytes (0x7F for a pulse, 0xFF for a space) followed by a byte for the remainder. A run of exactly 127 ticks gives one byte only, and no byte ever has a length field of 0.
- R5: After IDLE_BYTES consecutive full space bytes, lineIdle goes high and no byte is written until a pulse is sampled. That pulse clears lineIdle.
- R6: When invertIn is high, the line level is inverted before sampling, so a low irIn counts as a pulse.
- R7: While rxDisable is high no byte is written and the sampler returns to the idle state.
- R8: Bytes are read out in the order they were written. lineStatus bit 0 is high while the FIFO holds data, hostRd removes the head byte, and rxByte reads 0x00 when the FIFO is empty.
- R9: A byte that arrives while the FIFO is full, with no read in the same cycle, is dropped and sets lineStatus bit 1. That bit stays set until a statusRd strobe clears it.
- R10: irqStatus bit 0 equals data present AND rxIntEn, irqStatus bit 2 equals overrun AND errIntEn, and irq is high whenever either bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irIn | input | 1 | Demodulated receiver line, high = emitter on (before inversion) |
| invertIn | input | 1 | Inverts irIn before sampling |
| rxDisable | input | 1 | Holds the sampler idle and stops byte writes |
| rxIntEn | input | 1 | Enables the data-present interrupt |
| errIntEn | input | 1 | Enables the overrun interrupt |
| hostRd | input | 1 | Removes the head byte from the FIFO |
| statusRd | input | 1 | Status read strobe, clears the overrun bit |
| rxByte | output | 8 | Head byte of the FIFO, 0x00 when empty |
| lineStatus | output | 8 | Bit 0 data present, bit 1 overrun |
| irqStatus | output | 8 | Bit 0 data interrupt, bit 2 overrun interrupt |
| irq | output | 1 | Interrupt request |
| lineIdle | output | 1 | Line idle after a long space |

## Verification
The assertions assume that statusRd and hostRd are single strobes that may arrive in any cycle. They also assume that irIn can change at any clock, since it passes through the synchroniser before any run logic sees it. In the bench, every line level is held for a whole number of tick periods, so each run length comes out exact. invertIn is changed only while rxDisable is high, so a change of polarity cannot reach the counter as a false short pulse.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int RUN_W = 7;
  localparam logic [RUN_W-1:0] RUN_FULL = '1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_FULL - 1'b1;

  typedef struct packed {
    logic       push;
    logic [7:0] data;
  } rxPushT;
endpackage

// File: rtl/ir_rx_ctrl.sv
module ir_rx_ctrl
  import ir_rx_pkg::*;
#(
  parameter int TICK_CYCLES = 2000,
  parameter int IDLE_BYTES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   irIn,
  input  logic   invertIn,
  input  logic   rxDisable,
  output rxPushT pushOut,
  output logic   lineIdle
);
  localparam int DIV_W  = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int IDLE_W = $clog2(IDLE_BYTES + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(TICK_CYCLES - 1);
  localparam logic [IDLE_W-1:0] IDLE_GOAL = IDLE_W'(IDLE_BYTES);

  // input synchroniser
  logic [SYNC_STAGES-1:0] syncQ;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= irIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], irIn};
    end
  endgenerate

  logic samplePulse;
  assign samplePulse = syncQ[SYNC_STAGES-1] ^ invertIn;

  // tick divider
  logic [DIV_W-1:0] divCnt;
  logic tick;
  assign tick = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                  divCnt <= '0;
    else if (rxDisable || tick) divCnt <= '0;
    else                        divCnt <= divCnt + 1'b1;

  // run tracking
  logic             isSpace, isSpaceNext;
  logic [RUN_W-1:0] runCnt, runCntNext;
  logic             idleQ, idleNext;
  logic [IDLE_W-1:0] fullCnt, fullCntNext;
  rxPushT           pushNext;

  always_comb begin
    isSpaceNext   = isSpace;
    runCntNext    = runCnt;
    idleNext      = idleQ;
    fullCntNext   = fullCnt;
    pushNext.push = 1'b0;
    pushNext.data = {isSpace, runCnt};
    if (rxDisable) begin
      isSpaceNext = 1'b1;
      runCntNext  = '0;
      idleNext    = 1'b1;
      fullCntNext = '0;
    end else if (tick) begin
      if (idleQ) begin
        if (samplePulse) begin
          isSpaceNext = 1'b0;
          runCntNext  = RUN_W'(1);
          idleNext    = 1'b0;
          fullCntNext = '0;
        end
      end else if (samplePulse == isSpace) begin
        // level changed: close the pending run
        pushNext.push = (runCnt != '0);
        isSpaceNext   = !samplePulse;
        runCntNext    = RUN_W'(1);
        fullCntNext   = '0;
      end else if (runCnt == RUN_LAST) begin
        pushNext.push = 1'b1;
        pushNext.data = {isSpace, RUN_FULL};
        runCntNext    = '0;
        if (isSpace) begin
          fullCntNext = fullCnt + 1'b1;
          if (fullCnt + 1'b1 == IDLE_GOAL) idleNext = 1'b1;
        end
      end else begin
        runCntNext = runCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      isSpace <= 1'b1;
      runCnt  <= '0;
      idleQ   <= 1'b1;
      fullCnt <= '0;
    end else begin
      isSpace <= isSpaceNext;
      runCnt  <= runCntNext;
      idleQ   <= idleNext;
      fullCnt <= fullCntNext;
    end

  assign pushOut  = pushNext;
  assign lineIdle = idleQ;
endmodule

// File: rtl/ir_rx_datapath.sv
module ir_rx_datapath
  import ir_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  rxPushT     pushIn,
  input  logic       hostRd,
  input  logic       statusRd,
  input  logic       rxIntEn,
  input  logic       errIntEn,
  output logic [7:0] rxByte,
  output logic [7:0] lineStatus,
  output logic [7:0] irqStatus,
  output logic       irq
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             overrunQ;

  logic empty, full, doPop, doPush, overflowEv;
  assign empty      = (count == '0);
  assign full       = (count == CNT_FULL);
  assign doPop      = hostRd && !empty;
  assign doPush     = pushIn.push && (!full || doPop);
  assign overflowEv = pushIn.push && full && !doPop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (doPush) mem[wrPtr] <= pushIn.data;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           overrunQ <= 1'b0;
    else if (overflowEv) overrunQ <= 1'b1;
    else if (statusRd)   overrunQ <= 1'b0;

  assign rxByte     = empty ? 8'h00 : mem[rdPtr];
  assign lineStatus = {6'b0, overrunQ, !empty};
  assign irqStatus  = {5'b0, overrunQ && errIntEn, 1'b0, !empty && rxIntEn};
  assign irq        = |irqStatus;
endmodule

// File: rtl/ir_rx_sampler.sv
module ir_rx_sampler
  import ir_rx_pkg::*;
#(
  parameter int TICK_CYCLES = 2000,
  parameter int IDLE_BYTES  = 2,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       irIn,
  input  logic       invertIn,
  input  logic       rxDisable,
  input  logic       rxIntEn,
  input  logic       errIntEn,
  input  logic       hostRd,
  input  logic       statusRd,
  output logic [7:0] rxByte,
  output logic [7:0] lineStatus,
  output logic [7:0] irqStatus,
  output logic       irq,
  output logic       lineIdle
);
  rxPushT rxPush;

  ir_rx_ctrl #(
    .TICK_CYCLES(TICK_CYCLES),
    .IDLE_BYTES (IDLE_BYTES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .irIn     (irIn),
    .invertIn (invertIn),
    .rxDisable(rxDisable),
    .pushOut  (rxPush),
    .lineIdle (lineIdle)
  );

  ir_rx_datapath #(
    .DEPTH(FIFO_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pushIn    (rxPush),
    .hostRd    (hostRd),
    .statusRd  (statusRd),
    .rxIntEn   (rxIntEn),
    .errIntEn  (errIntEn),
    .rxByte    (rxByte),
    .lineStatus(lineStatus),
    .irqStatus (irqStatus),
    .irq       (irq)
  );
endmodule

// File: rtl/ir_rx_sampler_chk.sv
module ir_rx_sampler_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxDisable,
  input logic       statusRd,
  input logic       rxIntEn,
  input logic       errIntEn,
  input logic       pushValid,
  input logic [7:0] pushData,
  input logic [7:0] lineStatus,
  input logic       irq,
  input logic       lineIdle
);
  assert_no_zero_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> pushData[6:0] != 7'd0);

  assert_disable_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxDisable |-> !pushValid);

  assert_idle_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    lineIdle |-> !pushValid);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lineStatus[1] && !statusRd) |=> lineStatus[1]);

  assert_overrun_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !pushValid) |=> !lineStatus[1]);

  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineStatus[1]) |-> $past(pushValid));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((lineStatus[0] && rxIntEn) || (lineStatus[1] && errIntEn)));
endmodule

bind ir_rx_sampler ir_rx_sampler_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rxDisable (rxDisable),
  .statusRd  (statusRd),
  .rxIntEn   (rxIntEn),
  .errIntEn  (errIntEn),
  .pushValid (rxPush.push),
  .pushData  (rxPush.data),
  .lineStatus(lineStatus),
  .irq       (irq),
  .lineIdle  (lineIdle)
);

// File: tb/sim_ir_rx_sampler.sv
`timescale 1ns/1ps
module sim_ir_rx_sampler;
  localparam int TICK  = 4;
  localparam int IDLEB = 2;
  localparam int DEPTH = 4;
  localparam int VEC_N = 6;
  // each row: pulse ticks, space ticks
  localparam int VEC [VEC_N][2] = '{'{5, 3}, '{127, 10}, '{130, 126},
                                    '{1, 1}, '{60, 127}, '{2, 140}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irIn = 1'b0, invertIn = 1'b0, rxDisable = 1'b0;
  logic rxIntEn = 1'b1, errIntEn = 1'b1;
  logic readerRd = 1'b0, manRd = 1'b0, statusRd = 1'b0;
  logic hostRd;
  logic [7:0] rxByte, lineStatus, irqStatus;
  logic irq, lineIdle;
  assign hostRd = readerRd | manRd;

  always #2.5 clk = ~clk;

  ir_rx_sampler #(.TICK_CYCLES(TICK), .IDLE_BYTES(IDLEB), .FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .irIn(irIn), .invertIn(invertIn), .rxDisable(rxDisable),
    .rxIntEn(rxIntEn), .errIntEn(errIntEn), .hostRd(hostRd), .statusRd(statusRd),
    .rxByte(rxByte), .lineStatus(lineStatus), .irqStatus(irqStatus), .irq(irq),
    .lineIdle(lineIdle));

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  bit autoRead = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic addRun(input bit sp, input int n);
    int left = n;
    while (left >= 127) begin
      expQ.push_back({sp, 7'h7F});
      left -= 127;
    end
    if (left > 0) expQ.push_back({sp, 7'(left)});
  endtask

  task automatic sendRun(input logic lvl, input int ticks);
    irIn = lvl;
    repeat (ticks * TICK) @(negedge clk);
  endtask

  task automatic popCheck(input logic [7:0] exp, input string req);
    check(rxByte == exp && lineStatus[0], req, rxByte, exp);
    manRd = 1'b1;
    @(negedge clk);
    manRd = 1'b0;
  endtask

  // background reader, R8 ordering with R2 R3 R4 contents
  initial forever begin
    @(negedge clk);
    readerRd = 1'b0;
    if (autoRead && lineStatus[0]) begin
      if (expQ.size() == 0) check(1'b0, "R5 R8 unexpected byte", rxByte, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(rxByte == e, "R2 R3 R4 byte", rxByte, e);
      end
      readerRd = 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(lineStatus == 8'h00, "R1 lineStatus", lineStatus, 0);
    check(irqStatus == 8'h00 && !irq, "R1 irq", irqStatus, 0);
    check(lineIdle == 1'b1, "R1 lineIdle", lineIdle, 1);
    check(rxByte == 8'h00, "R1 R8 rxByte", rxByte, 0);

    // vector table walk, R2 R3 R4
    autoRead = 1'b1;
    for (int i = 0; i < VEC_N; i++) begin
      addRun(1'b0, VEC[i][0]);
      addRun(1'b1, VEC[i][1]);
      sendRun(1'b1, VEC[i][0]);
      sendRun(1'b0, VEC[i][1]);
    end
    // closing pulse then long space: R5 idle entry
    expQ.push_back(8'h04);
    expQ.push_back(8'hFF);
    expQ.push_back(8'hFF);
    sendRun(1'b1, 4);
    check(lineIdle == 1'b0, "R5 pulse clears idle", lineIdle, 0);
    sendRun(1'b0, 300);
    check(lineIdle == 1'b1, "R5 idle after full spaces", lineIdle, 1);
    check(expQ.size() == 0, "R5 all bytes seen", expQ.size(), 0);
    check(lineStatus == 8'h00, "R5 no bytes while idle", lineStatus, 0);
    autoRead = 1'b0;
    repeat (2) @(negedge clk);

    // R10 interrupt gating
    rxIntEn = 1'b0;
    errIntEn = 1'b0;
    sendRun(1'b1, 3);
    sendRun(1'b0, 270);
    check(lineStatus[0] && !irq && irqStatus == 8'h00, "R10 masked", irqStatus, 0);
    rxIntEn = 1'b1;
    @(negedge clk);
    check(irqStatus == 8'h01 && irq, "R10 data irq", irqStatus, 8'h01);
    popCheck(8'h03, "R8 order");
    popCheck(8'hFF, "R8 order");
    popCheck(8'hFF, "R8 order");
    check(lineStatus == 8'h00 && rxByte == 8'h00 && !irq, "R8 empty reads zero", rxByte, 0);

    // R6 inversion, switched under disable
    rxDisable = 1'b1;
    invertIn = 1'b1;
    irIn = 1'b1;
    repeat (10) @(negedge clk);
    rxDisable = 1'b0;
    sendRun(1'b1, 20);
    check(lineStatus[0] == 1'b0 && lineIdle, "R6 high is space when inverted", lineStatus, 0);
    sendRun(1'b0, 6);
    check(lineIdle == 1'b0, "R6 low is pulse when inverted", lineIdle, 0);
    sendRun(1'b1, 270);
    popCheck(8'h06, "R6 inverted pulse byte");
    popCheck(8'hFF, "R6 space byte");
    popCheck(8'hFF, "R6 space byte");

    // R7 disable
    rxDisable = 1'b1;
    for (int k = 0; k < 4; k++) begin
      sendRun(1'b0, 5);
      sendRun(1'b1, 5);
    end
    check(lineStatus == 8'h00 && lineIdle, "R7 no bytes while disabled", lineStatus, 0);
    sendRun(1'b0, 3);
    invertIn = 1'b0;
    repeat (10) @(negedge clk);
    rxDisable = 1'b0;
    sendRun(1'b0, 300);
    check(lineStatus == 8'h00 && lineIdle, "R7 returns idle", lineStatus, 0);

    // R9 overrun
    errIntEn = 1'b1;
    rxIntEn = 1'b0;
    sendRun(1'b1, 2); sendRun(1'b0, 2);
    sendRun(1'b1, 2); sendRun(1'b0, 2);
    sendRun(1'b1, 2); sendRun(1'b0, 270);
    check(lineStatus == 8'h03, "R9 overrun set", lineStatus, 8'h03);
    check(irqStatus == 8'h04 && irq, "R9 R10 err irq", irqStatus, 8'h04);
    repeat (5) @(negedge clk);
    check(lineStatus[1] == 1'b1, "R9 overrun sticky", lineStatus, 8'h03);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
    check(lineStatus == 8'h01 && !irq, "R9 cleared by status read", lineStatus, 8'h01);
    popCheck(8'h02, "R9 R8 kept byte");
    popCheck(8'h82, "R9 R8 kept byte");
    popCheck(8'h02, "R9 R8 kept byte");
    popCheck(8'h82, "R9 R8 kept byte");
    check(lineStatus == 8'h00, "R9 late bytes dropped", lineStatus, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule